// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an eight-pin general-purpose I/O port attached to a simple synchronous register bus. Each pin has its own direction bit. A 1 makes the pin an output and a 0 makes it an input. The port drives an output value and an output enable for every pin, and it samples every input pin through a two-stage synchronizer.

The data register is not at a single address. It is reached through a window of word-aligned offsets, and the offset bits [9:2] act as a per-pin mask. A write changes only the pins whose mask bit is set, so software can update one pin without a read-modify-write. A read returns zero in every bit whose mask bit is clear, so a read at offset `1 << (n+2)` returns pin n alone. Data written to a pin that is an input is discarded, so the value must be written again once the pin is an output.

Top module: `mgpio_port`

## Requirements
- R1: After synchronous reset, all direction bits and all stored output bits are 0, so `pin_oe` and `pin_out` are 0 and every pin is an input.
- R2: A write at offset 0x400 loads the direction register from `bus_wdata`, where bit n set makes pin n an output. A read at 0x400 returns the direction register.
- R3: A write at a data offset (address bits [11:10] and [1:0] all 0) updates stored output bit n only when address bit n+2 is 1. Every other stored bit keeps its value.
- R4: A data write does not change the stored output bit of a pin whose direction bit is 0. After that pin is switched to output, it drives its earlier stored value until it is written again.
- R5: A data read returns 0 in bit n whenever address bit n+2 is 0.
- R6: On a data read, an unmasked bit of an output pin returns the stored output value. An unmasked bit of an input pin returns the pin sampled through two flops, so a level change on `pin_in` is readable by a read issued two clocks after it.
- R7: Offsets that are neither data offsets nor 0x400 read as 0, and writes to them change nothing.
- R8: `pin_oe` equals the direction register in every cycle.
- R9: `bus_rdata` is registered. It shows the read result in the cycle after `bus_re` is sampled high, and it is 0 in the cycle after a clock edge where `bus_re` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Asynchronous pin inputs |
| pin_out | output | 8 | Stored output values |
| pin_oe | output | 8 | Per-pin output enable |

## Verification
The hardest case to reach is a data write to a pin that is still an input, followed by a direction change. Only then does the discarded write show on `pin_out`. Random stimulus interleaves direction writes, masked data writes with random masks, and pin toggles, so pins often switch direction with stale stored data. A directed sequence writes all ones while every pin is an input, then turns all pins to outputs and expects zeros. Pin changes are followed by a two-clock settle before any read, so the synchronized value is the one the bench predicts.

// File: rtl/mgpio_pkg.sv
package mgpio_pkg;
    localparam int PIN_N   = 8;
    localparam int ADDR_W  = 12;
    localparam int MASK_LO = 2;
    localparam logic [ADDR_W-1:0] DIR_OFFSET = 12'h400;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_DATA = 2'd1,
        ACC_DIR  = 2'd2
    } access_t;

    typedef struct packed {
        access_t          kind;
        logic [PIN_N-1:0] mask;
    } decode_t;

    function automatic decode_t decode_addr(input logic [ADDR_W-1:0] a);
        decode_t d;
        d.mask = a[MASK_LO +: PIN_N];
        if (a == DIR_OFFSET)
            d.kind = ACC_DIR;
        else if (a[ADDR_W-1:MASK_LO+PIN_N] == '0 && a[MASK_LO-1:0] == '0)
            d.kind = ACC_DATA;
        else
            d.kind = ACC_NONE;
        return d;
    endfunction
endpackage

// File: rtl/mgpio_decode.sv
module mgpio_decode
    import mgpio_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output decode_t           dec
);
    always_comb dec = decode_addr(addr);
endmodule

// File: rtl/mgpio_sync.sv
module mgpio_sync
    import mgpio_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PIN_N-1:0] raw,
    output logic [PIN_N-1:0] synced
);
    generate
        for (genvar p = 0; p < PIN_N; p++) begin : g_pin
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], raw[p]};
            end
            assign synced[p] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/mgpio_regs.sv
module mgpio_regs
    import mgpio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  decode_t          dec,
    input  logic [PIN_N-1:0] wdata,
    output logic [PIN_N-1:0] dir_q,
    output logic [PIN_N-1:0] out_q
);
    logic [PIN_N-1:0] upd;

    always_comb begin
        upd = '0;
        if (we && dec.kind == ACC_DATA)
            upd = dec.mask & dir_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '0;
            out_q <= '0;
        end else begin
            if (we && dec.kind == ACC_DIR)
                dir_q <= wdata;
            out_q <= (out_q & ~upd) | (wdata & upd);
        end
    end
endmodule

// File: rtl/mgpio_port.sv
module mgpio_port
    import mgpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [PIN_N-1:0]  bus_wdata,
    input  logic              bus_re,
    output logic [PIN_N-1:0]  bus_rdata,
    input  logic [PIN_N-1:0]  pin_in,
    output logic [PIN_N-1:0]  pin_out,
    output logic [PIN_N-1:0]  pin_oe
);
    decode_t          dec;
    logic [PIN_N-1:0] dir_q, out_q, in_s, rd_next;

    mgpio_decode u_dec (.addr(bus_addr), .dec(dec));

    mgpio_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .raw(pin_in), .synced(in_s)
    );

    mgpio_regs u_regs (
        .clk(clk), .rst(rst), .we(bus_we), .dec(dec),
        .wdata(bus_wdata), .dir_q(dir_q), .out_q(out_q)
    );

    always_comb begin
        unique case (dec.kind)
            ACC_DATA: rd_next = dec.mask & ((dir_q & out_q) | (~dir_q & in_s));
            ACC_DIR:  rd_next = dir_q;
            default:  rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_re) bus_rdata <= rd_next;
        else             bus_rdata <= '0;
    end

    assign pin_out = out_q;
    assign pin_oe  = dir_q;
endmodule

// File: rtl/mgpio_port_chk.sv
module mgpio_port_chk
    import mgpio_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              bus_re,
    input logic [PIN_N-1:0]  bus_rdata,
    input logic [PIN_N-1:0]  pin_out,
    input logic [PIN_N-1:0]  pin_oe
);
    logic is_dir, is_data;
    assign is_dir  = (bus_addr == DIR_OFFSET);
    assign is_data = (bus_addr[ADDR_W-1:MASK_LO+PIN_N] == '0) && (bus_addr[1:0] == 2'b00);

    AST_RST_CLEAR: assert property (@(posedge clk)
        rst |=> (pin_oe == '0 && pin_out == '0)); // R1
    AST_DIR_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && is_dir) |=> $stable(pin_oe)); // R8
    AST_OUT_ONLY_BY_DATA: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && is_data) |=> $stable(pin_out)); // R3
    AST_INPUT_PIN_KEEP: assert property (@(posedge clk) disable iff (rst)
        (bus_we && is_data) |=> ((pin_out ^ $past(pin_out)) & ~$past(pin_oe)) == '0); // R4
    AST_MASKED_READ: assert property (@(posedge clk) disable iff (rst)
        (bus_re && is_data) |=> (bus_rdata & ~$past(bus_addr[MASK_LO +: PIN_N])) == '0); // R5
    AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (rst)
        (bus_re && !is_data && !is_dir) |=> bus_rdata == '0); // R7
    AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (rst)
        !bus_re |=> bus_rdata == '0); // R9
endmodule

bind mgpio_port mgpio_port_chk u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_re(bus_re), .bus_rdata(bus_rdata), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/tb_mgpio_port.sv
module tb_mgpio_port;
    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] bus_addr;
    logic        bus_we, bus_re;
    logic [7:0]  bus_wdata, bus_rdata, pin_in, pin_out, pin_oe;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [7:0] m_dir = '0, m_out = '0, m_in = '0;

    always #4 clk = ~clk;

    mgpio_port dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    function automatic bit is_data(input logic [11:0] a);
        return a[11:10] == 2'b00 && a[1:0] == 2'b00;
    endfunction

    function automatic logic [7:0] exp_read(input logic [11:0] a);
        if (a == 12'h400) return m_dir;
        if (is_data(a))   return a[9:2] & ((m_dir & m_out) | (~m_dir & m_in));
        return 8'h00;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        if (a == 12'h400) m_dir = d;
        else if (is_data(a)) m_out = (m_out & ~(a[9:2] & m_dir)) | (d & a[9:2] & m_dir);
    endtask

    task automatic bus_read(input logic [11:0] a, input string req);
        logic [7:0] e;
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        e = exp_read(a);
        @(negedge clk);
        bus_re = 1'b0;
        check(req, bus_rdata, e);
        @(negedge clk);
        check("R9", bus_rdata, 8'h00);
    endtask

    task automatic set_pins(input logic [7:0] v);
        @(negedge clk);
        pin_in = v;
        m_in = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic check_pins(input string req);
        check({req, " oe"}, pin_oe, m_dir);
        check({req, " out"}, pin_out, m_out);
    endtask

    initial begin
        for (int c = 0; c < 200000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        rst = 1'b1; bus_addr = '0; bus_we = 0; bus_re = 0; bus_wdata = '0; pin_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_pins("R1");
        bus_read(12'h400, "R1 dir");

        // R4: write all ones while all pins are inputs, then make outputs
        bus_write(12'h3FC, 8'hFF);
        check_pins("R4");
        bus_write(12'h400, 8'hFF);
        check("R4 stale", pin_out, 8'h00);
        check("R8", pin_oe, 8'hFF);
        bus_read(12'h400, "R2");
        // R3: single-pin write through mask for pin 5
        bus_write(12'h080, 8'hFF);
        check("R3 single", pin_out, 8'h20);
        bus_write(12'h3FC, 8'h5A);
        check("R3 full", pin_out, 8'h5A);
        bus_read(12'h010, "R5 pin2");
        bus_read(12'h000, "R5 none");
        // R6: input pins through synchronizer
        bus_write(12'h400, 8'h0F);
        set_pins(8'hC3);
        bus_read(12'h3FC, "R6 mixed");
        bus_read(12'h200, "R6 pin7");
        // R7: unmapped offsets
        bus_write(12'h404, 8'hFF);
        bus_write(12'h3FD, 8'hFF);
        bus_write(12'h800, 8'hFF);
        check_pins("R7");
        bus_read(12'h404, "R7 rd");
        bus_read(12'h3FE, "R7 rd");
        bus_read(12'hC00, "R7 rd");

        for (int i = 0; i < 400; i++) begin
            int op;
            logic [11:0] a;
            op = $urandom_range(0, 5);
            a = {2'b00, 8'($urandom), 2'b00};
            case (op)
                0: bus_write(12'h400, 8'($urandom));
                1, 2: bus_write(a, 8'($urandom));
                3: bus_read(a, "R5/R6 rand");
                4: set_pins(8'($urandom));
                default: begin
                    a = 12'($urandom);
                    if ($urandom_range(0, 1) == 0) bus_read(a, "R7 rand");
                    else bus_write(a, 8'($urandom));
                end
            endcase
            check_pins("R3/R8 rand");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule